// File: doc/BRIEF.md
# Multicore Tick Timer with Shared Count

This block gives every core of a multicore cluster the same time base. One free-running count register is shared by all cores. Each core owns a mode register that holds a period, an operating mode, an interrupt enable and an interrupt-pending flag. A core raises its timer interrupt when the shared count, masked to the width of the period field, equals that core's period.

Software reaches the registers through a special-purpose register (SPR) write port and a separate combinational read port. Both ports carry the index of the core making the access, so one mode-register address reaches a different register for each core.

A match in restart mode clears the shared count for every core. A match in one-shot mode halts the shared counter until software next writes a mode register.

Top module: `tick_timer_mc`

## Requirements
- R1: While running, the shared count increments once every TICK_DIV clock cycles. The default of 10 gives 50 ns per increment at 200 MHz. The first increment lands TICK_DIV cycles after the write that starts the counter.
- R2: The count register sits at SPR address 0x5001, which is group 10 shifted left by 11 plus index 1. A write from any core replaces the value that every core reads there. A count write takes priority over a restart clear or an increment in the same cycle.
- R3: Each core's mode register sits at SPR address 0x5000, chosen by the core index on the port. Its layout is: period in bits [PERIOD_W-1:0], pending at bit PERIOD_W, interrupt enable at bit PERIOD_W+1, and mode code in bits [PERIOD_W+3:PERIOD_W+2]. Upper bits read as zero.
- R4: Mode code 01 is restart. When an increment would occur while the masked count equals the masked period, the count becomes 0 instead.
- R5: Mode codes 00 (disabled) and 11 (reserved) take no event and do not keep the counter running. With the enable bit at 0, an event still acts on the count but never sets pending.
- R6: An event sets pending when the enable bit is 1, and the core's interrupt output follows pending. Pending stays set until a write to that mode register carries 0 in the pending bit. A written 1 never sets it.
- R7: Mode code 10 is one-shot. A match halts the shared counter, which holds the match value. A write to any mode register releases the halt.
- R8: Reset clears the count, every mode register and the halt. The counter runs only while at least one core is in restart or one-shot mode and no halt is in force.
- R9: Only the low PERIOD_W bits of the count take part in the compare. If the period is not above the masked count, the match comes only after the count wraps through the top of the period field.
- R10: When several cores are in restart mode, the first core to match clears the count that all cores see. A core with a longer period then never reaches its match.
- R11: SPR addresses other than the two above read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| spr_we_i | input | 1 | SPR write strobe |
| spr_wcore_i | input | CORE_W | Index of the core issuing the write |
| spr_waddr_i | input | 16 | SPR write address |
| spr_wdata_i | input | CNT_W | SPR write data |
| spr_rcore_i | input | CORE_W | Index of the core issuing the read |
| spr_raddr_i | input | 16 | SPR read address |
| spr_rdata_o | output | CNT_W | Combinational read data |
| timer_irq_o | output | N_CORES | Per-core timer interrupt, equal to that core's pending flag |

## Verification
The bench targets the wrap case, where the period lies below the starting count. A design that compared full-width values, or used magnitude in place of equality, would fire early or never. Two cores in restart with different periods check that the shorter one starves the longer one; a per-core count copy would let both fire. One-shot checks that the count freezes at the match value and resumes only after a mode write, and the exact cycle of the first increment catches an off-by-one prescaler. Pending is checked both for persisting and for ignoring a written 1, which catches a design that copies the written bit.

// File: rtl/tt_pkg.sv
package tt_pkg;

   typedef enum logic [1:0] {
      TM_OFF     = 2'b00,
      TM_RESTART = 2'b01,
      TM_ONESHOT = 2'b10,
      TM_RSVD    = 2'b11
   } tmode_e;

   localparam int unsigned SPR_AW = 16;

   function automatic logic [SPR_AW-1:0] spr_addr(input int unsigned grp, input int unsigned idx);
      return SPR_AW'((grp << 11) + idx);
   endfunction

   localparam logic [SPR_AW-1:0] ADDR_MODE  = spr_addr(10, 0);
   localparam logic [SPR_AW-1:0] ADDR_COUNT = spr_addr(10, 1);

endpackage

// File: rtl/tt_tick_gen.sv
module tt_tick_gen #(
   parameter int unsigned TICK_DIV = 10
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic tick_o
);
   if (TICK_DIV == 1) begin : g_direct
      assign tick_o = run_i;
   end else begin : g_div
      localparam int unsigned DIV_W = $clog2(TICK_DIV);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni || !run_i) begin
            div_q <= '0;
         end else if (div_q == LAST) begin
            div_q <= '0;
         end else begin
            div_q <= div_q + 1'b1;
         end
      end

      assign tick_o = run_i && (div_q == LAST);
   end
endmodule

// File: rtl/tt_shared_count.sv
module tt_shared_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             tick_i,
   input  logic             clr_i,
   input  logic             stop_i,
   input  logic             resume_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             halt_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             halt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (we_i) begin
         cnt_q <= wdata_i;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (tick_i && !stop_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         halt_q <= 1'b0;
      end else if (resume_i) begin
         halt_q <= 1'b0;
      end else if (stop_i) begin
         halt_q <= 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign halt_o = halt_q;
endmodule

// File: rtl/tt_core_slot.sv
module tt_core_slot
   import tt_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned PERIOD_W = 28
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_i,
   input  logic [CNT_W-1:0]    wdata_i,
   input  logic [PERIOD_W-1:0] cnt_low_i,
   input  logic                tick_i,
   output logic [CNT_W-1:0]    word_o,
   output logic                active_o,
   output logic                restart_hit_o,
   output logic                oneshot_hit_o,
   output logic                irq_o
);
   localparam int unsigned MODE_W = PERIOD_W + 4;
   localparam int unsigned PEND_B = PERIOD_W;
   localparam int unsigned IE_B   = PERIOD_W + 1;
   localparam int unsigned MD_LO  = PERIOD_W + 2;

   logic [PERIOD_W-1:0] period_q;
   logic                pend_q;
   logic                ie_q;
   tmode_e              mode_q;
   logic                match;
   logic                raise;

   assign active_o      = (mode_q == TM_RESTART) || (mode_q == TM_ONESHOT);
   assign match         = tick_i && active_o && (cnt_low_i == period_q);
   assign restart_hit_o = match && (mode_q == TM_RESTART);
   assign oneshot_hit_o = match && (mode_q == TM_ONESHOT);
   assign raise         = match && ie_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         period_q <= '0;
         pend_q   <= 1'b0;
         ie_q     <= 1'b0;
         mode_q   <= TM_OFF;
      end else if (wr_i) begin
         period_q <= wdata_i[PERIOD_W-1:0];
         ie_q     <= wdata_i[IE_B];
         mode_q   <= tmode_e'(wdata_i[MD_LO +: 2]);
         pend_q   <= (pend_q && wdata_i[PEND_B]) || raise;
      end else begin
         pend_q   <= pend_q || raise;
      end
   end

   if (CNT_W > MODE_W) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wdata_i[CNT_W-1:MODE_W];
      assign word_o    = {{(CNT_W - MODE_W){1'b0}}, mode_q, ie_q, pend_q, period_q};
   end else begin : g_full
      assign word_o = {mode_q, ie_q, pend_q, period_q};
   end

   assign irq_o = pend_q;
endmodule

// File: rtl/tick_timer_mc.sv
module tick_timer_mc
   import tt_pkg::*;
#(
   parameter int unsigned N_CORES  = 2,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned PERIOD_W = 28,
   parameter int unsigned TICK_DIV = 10,
   localparam int unsigned CORE_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                spr_we_i,
   input  logic [CORE_W-1:0]   spr_wcore_i,
   input  logic [15:0]         spr_waddr_i,
   input  logic [CNT_W-1:0]    spr_wdata_i,
   input  logic [CORE_W-1:0]   spr_rcore_i,
   input  logic [15:0]         spr_raddr_i,
   output logic [CNT_W-1:0]    spr_rdata_o,
   output logic [N_CORES-1:0]  timer_irq_o
);
   if (PERIOD_W + 4 > CNT_W) begin : g_bad_width
      $error("tick_timer_mc: PERIOD_W + 4 must fit in CNT_W");
   end
   if (N_CORES < 1) begin : g_bad_cores
      $error("tick_timer_mc: N_CORES must be at least 1");
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("tick_timer_mc: TICK_DIV must be at least 1");
   end

   logic [CNT_W-1:0]         cnt_q;
   logic                     halt_q;
   logic                     tick;
   logic                     running;
   logic                     cnt_we;
   logic [N_CORES-1:0]       mode_wr;
   logic [N_CORES-1:0]       active;
   logic [N_CORES-1:0]       rst_hit;
   logic [N_CORES-1:0]       one_hit;
   logic [CNT_W-1:0]         mode_rd [N_CORES];
   logic [N_CORES*CNT_W-1:0] mode_flat;

   assign cnt_we  = spr_we_i && (spr_waddr_i == ADDR_COUNT);
   assign running = (|active) && !halt_q;

   tt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (running),
      .tick_o (tick)
   );

   tt_shared_count #(.CNT_W(CNT_W)) u_count (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (cnt_we),
      .wdata_i  (spr_wdata_i),
      .tick_i   (tick),
      .clr_i    (|rst_hit),
      .stop_i   (|one_hit),
      .resume_i (|mode_wr),
      .cnt_o    (cnt_q),
      .halt_o   (halt_q)
   );

   for (genvar i = 0; i < N_CORES; i++) begin : g_core
      assign mode_wr[i] = spr_we_i && (spr_waddr_i == ADDR_MODE) && (spr_wcore_i == CORE_W'(i));

      tt_core_slot #(.CNT_W(CNT_W), .PERIOD_W(PERIOD_W)) u_slot (
         .clk_i         (clk_i),
         .rst_ni        (rst_ni),
         .wr_i          (mode_wr[i]),
         .wdata_i       (spr_wdata_i),
         .cnt_low_i     (cnt_q[PERIOD_W-1:0]),
         .tick_i        (tick),
         .word_o        (mode_rd[i]),
         .active_o      (active[i]),
         .restart_hit_o (rst_hit[i]),
         .oneshot_hit_o (one_hit[i]),
         .irq_o         (timer_irq_o[i])
      );

      assign mode_flat[i*CNT_W +: CNT_W] = mode_rd[i];
   end

   always_comb begin
      spr_rdata_o = '0;
      if (spr_raddr_i == ADDR_COUNT) begin
         spr_rdata_o = cnt_q;
      end else if (spr_raddr_i == ADDR_MODE) begin
         for (int i = 0; i < N_CORES; i++) begin
            if (spr_rcore_i == CORE_W'(i)) spr_rdata_o = mode_rd[i];
         end
      end
   end
endmodule

// File: rtl/tick_timer_mc_chk.sv
module tick_timer_mc_chk
   import tt_pkg::*;
#(
   parameter int unsigned N_CORES  = 2,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned PERIOD_W = 28,
   parameter int unsigned CORE_W   = 1
) (
   input logic                     clk_i,
   input logic                     rst_ni,
   input logic                     spr_we_i,
   input logic [CORE_W-1:0]        spr_wcore_i,
   input logic [15:0]              spr_waddr_i,
   input logic [CNT_W-1:0]         spr_wdata_i,
   input logic [CNT_W-1:0]         cnt_i,
   input logic                     halt_i,
   input logic [N_CORES*CNT_W-1:0] mode_flat_i,
   input logic [N_CORES-1:0]       irq_i
);
   logic cnt_wr;
   logic any_mode_wr;
   assign cnt_wr      = spr_we_i && (spr_waddr_i == ADDR_COUNT);
   assign any_mode_wr = spr_we_i && (spr_waddr_i == ADDR_MODE);

   // R1 / R4: without a count write the count only holds, steps by one, or clears
   a_r1_step_or_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_wr |=> (cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) + 1'b1) || (cnt_i == '0));

   // R2: a count write from any core lands in the shared count
   a_r2_count_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_wr |=> (cnt_i == $past(spr_wdata_i)));

   // R7: while halted with no writes the count is frozen
   a_r7_halt_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halt_i && !cnt_wr && !any_mode_wr) |=> $stable(cnt_i));

   for (genvar i = 0; i < N_CORES; i++) begin : g_core
      logic [1:0] md;
      logic       own_wr;
      assign md     = mode_flat_i[i*CNT_W + PERIOD_W + 2 +: 2];
      assign own_wr = any_mode_wr && (spr_wcore_i == CORE_W'(i));

      // R6: pending persists until its own mode register is written
      a_r6_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (irq_i[i] && !own_wr) |=> irq_i[i]);

      // R5: a core in disabled or reserved mode never raises its interrupt
      a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!irq_i[i] && (md != 2'b01) && (md != 2'b10)) |=> !irq_i[i]);
   end
endmodule

bind tick_timer_mc tick_timer_mc_chk #(
   .N_CORES  (N_CORES),
   .CNT_W    (CNT_W),
   .PERIOD_W (PERIOD_W),
   .CORE_W   (CORE_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .spr_we_i    (spr_we_i),
   .spr_wcore_i (spr_wcore_i),
   .spr_waddr_i (spr_waddr_i),
   .spr_wdata_i (spr_wdata_i),
   .cnt_i       (cnt_q),
   .halt_i      (halt_q),
   .mode_flat_i (mode_flat),
   .irq_i       (timer_irq_o)
);

// File: tb/tick_timer_mc_tb.sv
`timescale 1ns/1ps
module tick_timer_mc_tb;
   localparam int unsigned NC  = 2;
   localparam int unsigned CW  = 32;
   localparam int unsigned PW  = 4;
   localparam logic [15:0] A_MODE  = 16'h5000;
   localparam logic [15:0] A_COUNT = 16'h5001;
   localparam logic [1:0]  M_OFF = 2'b00, M_RST = 2'b01, M_ONE = 2'b10, M_RSV = 2'b11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          we = 1'b0;
   logic [0:0]    wcore = '0;
   logic [15:0]   waddr = '0;
   logic [CW-1:0] wdata = '0;
   logic [0:0]    rcore = '0;
   logic [15:0]   raddr = '0;
   logic [CW-1:0] rdata;
   logic [NC-1:0] irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   tick_timer_mc #(.N_CORES(NC), .CNT_W(CW), .PERIOD_W(PW), .TICK_DIV(10)) u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .spr_we_i    (we),
      .spr_wcore_i (wcore),
      .spr_waddr_i (waddr),
      .spr_wdata_i (wdata),
      .spr_rcore_i (rcore),
      .spr_raddr_i (raddr),
      .spr_rdata_o (rdata),
      .timer_irq_o (irq)
   );

   function automatic logic [CW-1:0] mw(logic [1:0] md, logic ie, logic pend, logic [PW-1:0] per);
      return CW'({md, ie, pend, per});
   endfunction

   task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      we = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic spr_wr(int core, logic [15:0] a, logic [CW-1:0] d);
      we = 1'b1; wcore = 1'(core); waddr = a; wdata = d;
      @(posedge clk);
      #1 we = 1'b0;
   endtask

   task automatic spr_rd(int core, logic [15:0] a, output logic [CW-1:0] d);
      rcore = 1'(core); raddr = a;
      #0.5 d = rdata;
   endtask

   task automatic run(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic t_reset_state();
      logic [CW-1:0] v;
      do_reset();
      spr_rd(0, A_COUNT, v); chk("R8 count after reset", v, 0);
      spr_rd(0, A_MODE, v);  chk("R8 mode0 after reset", v, 0);
      spr_rd(1, A_MODE, v);  chk("R8 mode1 after reset", v, 0);
      chk("R8 irq after reset", CW'(irq), 0);
      spr_wr(1, A_COUNT, 7);
      run(30);
      spr_rd(0, A_COUNT, v); chk("R8 count stays stopped", v, 7);
      spr_wr(0, A_MODE, mw(M_RSV, 1'b1, 1'b0, 4'd7));
      run(30);
      spr_rd(0, A_COUNT, v); chk("R5 reserved mode keeps counter stopped", v, 7);
      chk("R5 reserved mode raises no irq", CW'(irq), 0);
   endtask

   task automatic t_restart_rate();
      logic [CW-1:0] v;
      do_reset();
      spr_wr(0, A_MODE, mw(M_RST, 1'b1, 1'b0, 4'd3));
      run(9);  spr_rd(0, A_COUNT, v); chk("R1 no increment before TICK_DIV", v, 0);
      run(1);  spr_rd(0, A_COUNT, v); chk("R1 first increment at TICK_DIV", v, 1);
      run(29); spr_rd(0, A_COUNT, v); chk("R4 count reaches period", v, 3);
      chk("R6 no irq before match", CW'(irq), 0);
      run(1);  spr_rd(0, A_COUNT, v); chk("R4 restart clears count", v, 0);
      chk("R6 irq raised on match", CW'(irq), 2'b01);
      run(50); chk("R6 pending persists", CW'(irq), 2'b01);
      spr_rd(0, A_MODE, v); chk("R3 mode readback with pending", v, mw(M_RST, 1'b1, 1'b1, 4'd3));
      spr_wr(0, A_MODE, mw(M_RST, 1'b1, 1'b0, 4'd3));
      chk("R6 write of zero clears pending", CW'(irq), 0);
   endtask

   task automatic t_pend_write_one();
      logic [CW-1:0] v;
      do_reset();
      spr_wr(0, A_MODE, mw(M_OFF, 1'b0, 1'b1, 4'd5));
      spr_rd(0, A_MODE, v); chk("R6 written one does not set pending", v, mw(M_OFF, 1'b0, 1'b0, 4'd5));
      chk("R6 irq stays low", CW'(irq), 0);
   endtask

   task automatic t_no_enable();
      logic [CW-1:0] v;
      do_reset();
      spr_wr(0, A_MODE, mw(M_RST, 1'b0, 1'b0, 4'd2));
      run(29); spr_rd(0, A_COUNT, v); chk("R5 count at period", v, 2);
      run(1);  spr_rd(0, A_COUNT, v); chk("R5 event clears without enable", v, 0);
      chk("R5 no irq when enable is 0", CW'(irq), 0);
   endtask

   task automatic t_shared();
      logic [CW-1:0] v;
      do_reset();
      spr_wr(1, A_COUNT, 100);
      spr_rd(0, A_COUNT, v); chk("R2 core0 sees core1 count write", v, 100);
      spr_rd(1, A_COUNT, v); chk("R2 core1 sees its count write", v, 100);
      spr_wr(1, A_MODE, mw(M_OFF, 1'b1, 1'b0, 4'd9));
      spr_rd(1, A_MODE, v); chk("R3 core1 mode readback", v, mw(M_OFF, 1'b1, 1'b0, 4'd9));
      spr_rd(0, A_MODE, v); chk("R3 core0 mode untouched", v, 0);
   endtask

   task automatic t_oneshot();
      logic [CW-1:0] v;
      do_reset();
      spr_wr(1, A_MODE, mw(M_ONE, 1'b1, 1'b0, 4'd2));
      run(30); spr_rd(0, A_COUNT, v); chk("R7 count at match", v, 2);
      chk("R7 one-shot irq", CW'(irq), 2'b10);
      run(50); spr_rd(0, A_COUNT, v); chk("R7 count halted", v, 2);
      spr_wr(1, A_MODE, mw(M_ONE, 1'b1, 1'b0, 4'd4));
      run(29); spr_rd(0, A_COUNT, v); chk("R7 resumed after mode write", v, 4);
      chk("R7 irq cleared before second match", CW'(irq), 0);
      run(1);  chk("R7 second one-shot irq", CW'(irq), 2'b10);
      run(30); spr_rd(0, A_COUNT, v); chk("R7 halted again", v, 4);
   endtask

   task automatic t_wrap();
      logic [CW-1:0] v;
      do_reset();
      spr_wr(0, A_COUNT, 5);
      spr_wr(0, A_MODE, mw(M_RST, 1'b1, 1'b0, 4'd3));
      run(149); spr_rd(0, A_COUNT, v); chk("R9 count past mask top", v, 19);
      chk("R9 no early match", CW'(irq), 0);
      run(1);   spr_rd(0, A_COUNT, v); chk("R9 match after wrap clears", v, 0);
      chk("R9 irq after wrap", CW'(irq), 2'b01);
   endtask

   task automatic t_multi();
      logic [CW-1:0] v;
      do_reset();
      spr_wr(1, A_MODE, mw(M_RST, 1'b1, 1'b0, 4'd3));
      spr_wr(0, A_MODE, mw(M_RST, 1'b1, 1'b0, 4'd5));
      run(38); spr_rd(0, A_COUNT, v); chk("R10 count at shorter period", v, 3);
      run(1);  spr_rd(1, A_COUNT, v); chk("R10 shorter match clears shared count", v, 0);
      chk("R10 only shorter core interrupts", CW'(irq), 2'b10);
      run(160); spr_rd(0, A_COUNT, v); chk("R10 periodic clear", v, 0);
      chk("R10 longer core starved", CW'(irq[0]), 0);
   endtask

   task automatic t_unmapped();
      logic [CW-1:0] v;
      do_reset();
      spr_wr(0, 16'h5002, '1);
      spr_wr(1, 16'h4801, '1);
      spr_rd(0, A_COUNT, v); chk("R11 count unchanged", v, 0);
      spr_rd(0, A_MODE, v);  chk("R11 mode0 unchanged", v, 0);
      spr_rd(1, A_MODE, v);  chk("R11 mode1 unchanged", v, 0);
      spr_rd(0, 16'h5002, v); chk("R11 unmapped read is zero", v, 0);
   endtask

   initial begin
      t_reset_state();
      t_restart_rate();
      t_pend_write_one();
      t_no_enable();
      t_shared();
      t_oneshot();
      t_wrap();
      t_multi();
      t_unmapped();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule